// File: doc/BRIEF.md
# Polyphase I/Q Demodulator

This block turns a real, signed intermediate-frequency sample stream, one sample per clock, into complex baseband words. It does no mixing. Samples with an even index go into one highpass FIR branch, which produces the in-phase channel. Samples with an odd index go into a second highpass FIR branch, which produces the quadrature channel. The two branches are offset by a quarter cycle of the centre frequency, and the pair acts as one complex bandpass filter. The coefficients of each branch sum to zero, so a constant offset on the input is removed.

The datapath is fully pipelined and never stalls. Each branch output is rounded, saturated and registered. A demultiplexer then packs two consecutive results of a channel into an even word and an odd word. The output ports therefore change once every four input clocks, and a single-cycle strobe marks each new set of four words.

Top module: `iq_polyphase_demod`

## Requirements
- R1: Samples are numbered from the first clock edge at which `rst` is low; index 0 counts as even. Sample x[n] goes only to the I branch when n is even and only to the Q branch when n is odd, so that e[k]=x[2k] and o[k]=x[2k+1].
- R2: The raw I result is yI[k] = sum over j=0..6 of CI[j]·e[k−j], with CI = {2, −14, 50, −76, 50, −14, 2} for j = 0..6. Samples with a negative index count as 0.
- R3: The raw Q result is yQ[k] = sum over j=0..6 of CQ[j]·o[k−j], with CQ = {0, −6, 30, −72, 72, −30, 6} for j = 0..6. Samples with a negative index count as 0.
- R4: With a constant input, every output word is exactly 0 once k ≥ 6, which means for every output set m ≥ 3.
- R5: Each raw sum is scaled by adding 4 and then shifting arithmetically right by FRAC = 3 bits, which rounds half up.
- R6: The scaled value is clamped to the signed 12-bit range −2048..2047.
- R7: Output set m holds i_even = I[2m], i_odd = I[2m+1], q_even = Q[2m] and q_odd = Q[2m+1], all of them after rounding and clamping.
- R8: `out_valid` is high for exactly one cycle per set. Set m appears at the rising edge 4m+8 (edges counted from 0 as in R1), five edges after x[4m+3] is captured.
- R9: A synchronous reset clears the delay lines, the even/odd phase, the pairing state, all output words and `out_valid`. The first sample after reset is index 0, and it sees no history from before the reset.
- R10: Between two strobes, all four output words hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| if_sample | input | 8 | Signed IF sample, one per clock |
| i_even | output | 12 | In-phase result with even index |
| i_odd | output | 12 | In-phase result with odd index |
| q_even | output | 12 | Quadrature result with even index |
| q_odd | output | 12 | Quadrature result with odd index |
| out_valid | output | 1 | One-cycle strobe marking a new set of four words |

## Verification
The bench counts rising edges from the release of reset. After each edge it predicts whether this is edge 4m+8 for some m. At the falling edge that follows, it compares `out_valid` with that prediction, so the five-edge lag behind sample 4m+3 is checked on every cycle, including the cycles where no strobe is due. On a strobe cycle, the four words are compared with sums that the bench builds from the samples it drove. On every other cycle after the first set, the words are compared with the values they held on the previous cycle. Reset is checked at the falling edge after each reset edge, where every output must read zero.

// File: rtl/iqpd_pkg.sv
package iqpd_pkg;

   typedef enum logic {
      PH_EVEN = 1'b0,
      PH_ODD  = 1'b1
   } phase_e;

   // accumulator wide enough for TAPS full-scale products
   function automatic int acc_bits(input int in_w, input int coef_w, input int taps);
      return in_w + coef_w + $clog2(taps);
   endfunction

endpackage

// File: rtl/iqpd_phase_split.sv
module iqpd_phase_split
   import iqpd_pkg::*;
#(
   parameter int IN_W = 8
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic signed [IN_W-1:0] smp_in,
   output logic signed [IN_W-1:0] smp_q,
   output logic                   ld_even,
   output logic                   ld_odd
);

   phase_e phase;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase   <= PH_EVEN;
         smp_q   <= '0;
         ld_even <= 1'b0;
         ld_odd  <= 1'b0;
      end else begin
         smp_q   <= smp_in;
         ld_even <= (phase == PH_EVEN);
         ld_odd  <= (phase == PH_ODD);
         phase   <= (phase == PH_EVEN) ? PH_ODD : PH_EVEN;
      end
   end

   // R1
   load_excl_chk: assert property (@(posedge clk) $onehot0({ld_even, ld_odd}));

   // R1
   load_every_clk_chk: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (ld_even ^ ld_odd));

   // R1
   load_alt_chk: assert property (@(posedge clk) disable iff (rst)
      ld_even |=> ld_odd);

endmodule

// File: rtl/iqpd_round_sat.sv
module iqpd_round_sat #(
   parameter int IN_W  = 19,
   parameter int FRAC  = 3,
   parameter int OUT_W = 12
) (
   input  logic signed [IN_W-1:0]  acc,
   output logic signed [OUT_W-1:0] res
);

   localparam int EXT_W = IN_W + 1;
   localparam logic signed [EXT_W-1:0] HALF = EXT_W'(longint'(1) << (FRAC - 1));
   localparam logic signed [EXT_W-1:0] MAXV = {{(EXT_W - OUT_W + 1){1'b0}}, {(OUT_W - 1){1'b1}}};
   localparam logic signed [EXT_W-1:0] MINV = {{(EXT_W - OUT_W + 1){1'b1}}, {(OUT_W - 1){1'b0}}};

   logic signed [EXT_W-1:0] rnd;
   logic signed [EXT_W-1:0] shf;

   always_comb begin
      rnd = {acc[IN_W-1], acc} + HALF;
      shf = rnd >>> FRAC;
   end

   if (OUT_W >= EXT_W - FRAC) begin : g_no_clamp
      assign res = shf[OUT_W-1:0];
   end else begin : g_clamp
      always_comb begin
         if (shf > MAXV)      res = MAXV[OUT_W-1:0];
         else if (shf < MINV) res = MINV[OUT_W-1:0];
         else                 res = shf[OUT_W-1:0];
      end
   end

endmodule

// File: rtl/iqpd_fir_branch.sv
module iqpd_fir_branch #(
   parameter int                        IN_W   = 8,
   parameter int                        COEF_W = 8,
   parameter int                        TAPS   = 7,
   parameter logic [TAPS*COEF_W-1:0]    COEFS  = '0,
   parameter int                        FRAC   = 3,
   parameter int                        OUT_W  = 12
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    ld,
   input  logic signed [IN_W-1:0]  smp,
   output logic                    vout,
   output logic signed [OUT_W-1:0] y
);

   localparam int PROD_W = IN_W + COEF_W;
   localparam int ACC_W  = iqpd_pkg::acc_bits(IN_W, COEF_W, TAPS);
   localparam longint SAT_HI = (longint'(1) << (OUT_W - 1 + FRAC)) - (longint'(1) << (FRAC - 1));
   localparam longint SAT_LO = -(longint'(1) << (OUT_W - 1 + FRAC)) - (longint'(1) << (FRAC - 1));
   localparam logic signed [OUT_W-1:0] Y_MAX = {1'b0, {(OUT_W - 1){1'b1}}};
   localparam logic signed [OUT_W-1:0] Y_MIN = {1'b1, {(OUT_W - 1){1'b0}}};

   logic signed [IN_W-1:0]   dl   [TAPS];
   logic signed [PROD_W-1:0] prod [TAPS];
   logic signed [ACC_W-1:0]  acc;
   logic signed [ACC_W-1:0]  acc_sum;
   logic signed [OUT_W-1:0]  y_nxt;
   logic                     v1, v2, v3;

   // delay line and stage strobes
   always_ff @(posedge clk) begin
      if (rst) begin
         for (int j = 0; j < TAPS; j++) dl[j] <= '0;
         v1   <= 1'b0;
         v2   <= 1'b0;
         v3   <= 1'b0;
         vout <= 1'b0;
         acc  <= '0;
         y    <= '0;
      end else begin
         v1   <= ld;
         v2   <= v1;
         v3   <= v2;
         vout <= v3;
         if (ld) begin
            dl[0] <= smp;
            for (int j = 1; j < TAPS; j++) dl[j] <= dl[j-1];
         end
         acc <= acc_sum;
         y   <= y_nxt;
      end
   end

   // one registered multiplier per nonzero tap
   for (genvar j = 0; j < TAPS; j++) begin : g_tap
      localparam logic signed [COEF_W-1:0] CJ = COEFS[j*COEF_W +: COEF_W];
      if (CJ == 0) begin : g_zero
         assign prod[j] = '0;
      end else begin : g_mul
         logic signed [PROD_W-1:0] p_r;
         always_ff @(posedge clk) begin
            if (rst)     p_r <= '0;
            else if (v1) p_r <= dl[j] * CJ;
         end
         assign prod[j] = p_r;
      end
   end

   always_comb begin
      acc_sum = '0;
      for (int j = 0; j < TAPS; j++) acc_sum = acc_sum + ACC_W'(prod[j]);
   end

   iqpd_round_sat #(
      .IN_W  (ACC_W),
      .FRAC  (FRAC),
      .OUT_W (OUT_W)
   ) u_round_sat (
      .acc (acc),
      .res (y_nxt)
   );

   // R8
   branch_latency_chk: assert property (@(posedge clk) disable iff (rst)
      ld |-> ##4 vout);

   // R6
   sat_hi_chk: assert property (@(posedge clk) disable iff (rst)
      (v3 && (longint'(acc) >= SAT_HI)) |=> (y == Y_MAX));

   // R6
   sat_lo_chk: assert property (@(posedge clk) disable iff (rst)
      (v3 && (longint'(acc) < SAT_LO)) |=> (y == Y_MIN));

endmodule

// File: rtl/iqpd_pair_demux.sv
module iqpd_pair_demux
   import iqpd_pkg::*;
#(
   parameter int W = 12
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                vin,
   input  logic signed [W-1:0] din,
   output logic signed [W-1:0] even_w,
   output logic signed [W-1:0] odd_w,
   output logic                vout
);

   phase_e              slot;
   logic signed [W-1:0] hold;

   always_ff @(posedge clk) begin
      if (rst) begin
         slot   <= PH_EVEN;
         hold   <= '0;
         even_w <= '0;
         odd_w  <= '0;
         vout   <= 1'b0;
      end else begin
         vout <= 1'b0;
         if (vin) begin
            if (slot == PH_EVEN) begin
               hold <= din;
               slot <= PH_ODD;
            end else begin
               even_w <= hold;
               odd_w  <= din;
               vout   <= 1'b1;
               slot   <= PH_EVEN;
            end
         end
      end
   end

   // R8
   strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
      vout |=> !vout);

   // R10
   word_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!vout && !$past(rst)) |-> ($stable(even_w) && $stable(odd_w)));

endmodule

// File: rtl/iq_polyphase_demod.sv
module iq_polyphase_demod #(
   parameter int                     IN_W   = 8,
   parameter int                     COEF_W = 8,
   parameter int                     TAPS   = 7,
   parameter logic [TAPS*COEF_W-1:0] COEF_I = 56'h02F232B432F202,
   parameter logic [TAPS*COEF_W-1:0] COEF_Q = 56'h06E248B81EFA00,
   parameter int                     FRAC   = 3,
   parameter int                     OUT_W  = 12
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic signed [IN_W-1:0]  if_sample,
   output logic signed [OUT_W-1:0] i_even,
   output logic signed [OUT_W-1:0] i_odd,
   output logic signed [OUT_W-1:0] q_even,
   output logic signed [OUT_W-1:0] q_odd,
   output logic                    out_valid
);

   localparam int ACC_W  = iqpd_pkg::acc_bits(IN_W, COEF_W, TAPS);
   localparam int N_CHAN = 2;

   // elaboration-time parameter checks
   if ((TAPS % 2) == 0 || TAPS < 3) begin : g_bad_taps
      $error("TAPS must be odd and at least 3");
   end
   if (FRAC < 1 || FRAC >= ACC_W) begin : g_bad_frac
      $error("FRAC must lie in 1..ACC_W-1");
   end
   if (OUT_W < 2 || OUT_W > ACC_W) begin : g_bad_outw
      $error("OUT_W must lie in 2..ACC_W");
   end

   logic signed [IN_W-1:0]  smp_r;
   logic                    ld_even, ld_odd;
   logic [N_CHAN-1:0]       dm_v;
   logic signed [OUT_W-1:0] dm_e [N_CHAN];
   logic signed [OUT_W-1:0] dm_o [N_CHAN];

   iqpd_phase_split #(
      .IN_W (IN_W)
   ) u_split (
      .clk     (clk),
      .rst     (rst),
      .smp_in  (if_sample),
      .smp_q   (smp_r),
      .ld_even (ld_even),
      .ld_odd  (ld_odd)
   );

   for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
      localparam logic [TAPS*COEF_W-1:0] CF = (c == 0) ? COEF_I : COEF_Q;

      logic                    ld_c;
      logic                    bv;
      logic signed [OUT_W-1:0] by;
      logic                    v_a;
      logic signed [OUT_W-1:0] y_a;
      logic signed [OUT_W-1:0] e_l, o_l;
      logic                    v_l;

      assign ld_c = (c == 0) ? ld_even : ld_odd;

      iqpd_fir_branch #(
         .IN_W   (IN_W),
         .COEF_W (COEF_W),
         .TAPS   (TAPS),
         .COEFS  (CF),
         .FRAC   (FRAC),
         .OUT_W  (OUT_W)
      ) u_branch (
         .clk  (clk),
         .rst  (rst),
         .ld   (ld_c),
         .smp  (smp_r),
         .vout (bv),
         .y    (by)
      );

      // the even branch sees its sample one clock earlier: realign it
      if (c == 0) begin : g_align
         always_ff @(posedge clk) begin
            if (rst) begin
               v_a <= 1'b0;
               y_a <= '0;
            end else begin
               v_a <= bv;
               y_a <= by;
            end
         end
      end else begin : g_direct
         assign v_a = bv;
         assign y_a = by;
      end

      iqpd_pair_demux #(
         .W (OUT_W)
      ) u_demux (
         .clk    (clk),
         .rst    (rst),
         .vin    (v_a),
         .din    (y_a),
         .even_w (e_l),
         .odd_w  (o_l),
         .vout   (v_l)
      );

      assign dm_e[c] = e_l;
      assign dm_o[c] = o_l;
      assign dm_v[c] = v_l;
   end

   assign i_even    = dm_e[0];
   assign i_odd     = dm_o[0];
   assign q_even    = dm_e[1];
   assign q_odd     = dm_o[1];
   assign out_valid = dm_v[1];

   // R7
   chan_align_chk: assert property (@(posedge clk) disable iff (rst)
      dm_v[0] == dm_v[1]);

   // R9
   rst_clear_chk: assert property (@(posedge clk)
      rst |=> (!out_valid && i_even == '0 && i_odd == '0 && q_even == '0 && q_odd == '0));

endmodule

// File: tb/test_iq_polyphase_demod.sv
module test_iq_polyphase_demod;

   localparam int MODE_TONE = 0;
   localparam int MODE_RAND = 1;
   localparam int MODE_DC   = 2;
   localparam int MODE_FS   = 3;
   localparam int MODE_TON8 = 4;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic               rst = 1'b1;
   logic signed [7:0]  smp = '0;
   logic signed [11:0] i_even, i_odd, q_even, q_odd;
   logic               out_valid;

   int checks = 0;
   int fails  = 0;
   int xs [0:1023];
   int ns = 0;
   int ec = 0;
   int mode = MODE_TONE;
   int ci [7] = '{2, -14, 50, -76, 50, -14, 2};
   int cq [7] = '{0, -6, 30, -72, 72, -30, 6};
   int p_ie, p_io, p_qe, p_qo;

   iq_polyphase_demod i_iq_polyphase_demod (
      .clk       (clk),
      .rst       (rst),
      .if_sample (smp),
      .i_even    (i_even),
      .i_odd     (i_odd),
      .q_even    (q_even),
      .q_odd     (q_odd),
      .out_valid (out_valid)
   );

   function automatic int ref_y(input int ch, input int k);
      int acc = 0;
      int r;
      for (int j = 0; j < 7; j++) begin
         if (k - j >= 0) acc += ((ch == 0) ? ci[j] : cq[j]) * xs[2 * (k - j) + ch];
      end
      r = (acc + 4) >>> 3;
      if (r > 2047)  r = 2047;
      if (r < -2048) r = -2048;
      return r;
   endfunction

   function automatic int gen(input int md, input int n);
      case (md)
         MODE_TONE: case (n % 4)
                       0: return 90;
                       1: return -40;
                       2: return -90;
                       default: return 40;
                    endcase
         MODE_RAND: return ((n * n * 37 + n * 101 + 13) & 255) - 128;
         MODE_DC:   return 77;
         MODE_FS:   return ((n % 4) < 2) ? 127 : -128;
         default:   case (n % 8)
                       0: return 0;
                       1: return 50;
                       2: return 70;
                       3: return 50;
                       4: return 0;
                       5: return -50;
                       6: return -70;
                       default: return -50;
                    endcase
      endcase
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d (edge %0d)", tag, act, exp, ec);
      end
   endtask

   task automatic observe();
      bit exp_v;
      int m;
      int e_ie, e_io, e_qe, e_qo;
      exp_v = (ec >= 9) && (((ec - 9) % 4) == 0);
      chk("R8 out_valid timing", int'(out_valid), int'(exp_v));
      if (exp_v) begin
         m    = (ec - 9) / 4;
         e_ie = ref_y(0, 2 * m);
         e_io = ref_y(0, 2 * m + 1);
         e_qe = ref_y(1, 2 * m);
         e_qo = ref_y(1, 2 * m + 1);
         chk("R1 R2 R5 R7 i_even", int'(i_even), e_ie);
         chk("R1 R2 R5 R7 i_odd",  int'(i_odd),  e_io);
         chk("R1 R3 R5 R7 q_even", int'(q_even), e_qe);
         chk("R1 R3 R5 R7 q_odd",  int'(q_odd),  e_qo);
         if (mode == MODE_DC && m >= 3) begin
            chk("R4 dc i_even", int'(i_even), 0);
            chk("R4 dc i_odd",  int'(i_odd),  0);
            chk("R4 dc q_even", int'(q_even), 0);
            chk("R4 dc q_odd",  int'(q_odd),  0);
         end
         if (mode == MODE_FS && m >= 3) begin
            chk("R6 i_even clipped", int'(i_even == 12'sd2047 || i_even == -12'sd2048), 1);
            chk("R6 q_odd clipped",  int'(q_odd == 12'sd2047 || q_odd == -12'sd2048), 1);
         end
      end else if (ec > 9) begin
         chk("R10 i_even held", int'(i_even), p_ie);
         chk("R10 i_odd held",  int'(i_odd),  p_io);
         chk("R10 q_even held", int'(q_even), p_qe);
         chk("R10 q_odd held",  int'(q_odd),  p_qo);
      end
      p_ie = int'(i_even);
      p_io = int'(i_odd);
      p_qe = int'(q_even);
      p_qo = int'(q_odd);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      smp = 8'sd55;
      for (int r = 0; r < 3; r++) begin
         @(posedge clk);
         @(negedge clk);
         chk("R9 out_valid in reset", int'(out_valid), 0);
         chk("R9 i_even in reset",    int'(i_even), 0);
         chk("R9 i_odd in reset",     int'(i_odd), 0);
         chk("R9 q_even in reset",    int'(q_even), 0);
         chk("R9 q_odd in reset",     int'(q_odd), 0);
      end
      rst = 1'b0;
      ns  = 0;
      ec  = 0;
   endtask

   task automatic step(input int x);
      smp    = 8'(x);
      xs[ns] = x;
      ns++;
      @(posedge clk);
      @(negedge clk);
      ec++;
      observe();
   endtask

   task automatic run(input int md, input int count);
      mode = md;
      for (int n = 0; n < count; n++) step(gen(md, n));
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog expired at edge %0d", ec);
      finish_run();
   end

   initial begin
      @(negedge clk);
      do_reset();
      run(MODE_TONE, 160);
      do_reset();
      run(MODE_RAND, 200);
      do_reset();
      run(MODE_DC, 100);
      do_reset();
      run(MODE_FS, 100);
      // R9: reset in the middle of a stream, then a fresh stream
      do_reset();
      run(MODE_TON8, 130);
      do_reset();
      run(MODE_RAND, 160);
      finish_run();
   end

endmodule